// File: doc/BRIEF.md
# External Memory Port Sequencer and Bus Arbiter

This block connects a processor core to an external memory bus that other masters can share. The core presents one access at a time. Each access carries an address, a memory space, a direction and write data. The block latches the access and drives the address, the three active-low space selects and the bus strobe. It then runs a read or write strobe. If the external wait input is high during the strobe, the strobe is held for extra clocks. When the strobe ends, the block returns read data together with a one-clock done pulse.

An external master asks for the bus through an active-low request pin. The block synchronizes that pin. It gives the bus away only at an instruction boundary and only when no access is in flight. It first floats all of its outputs and asserts grant one clock later. While the bus is granted away, the core may keep working internally. If the core needs the bus during that time, the block raises a stall to the core and asserts the active-low bus-needed pin, so an outside arbiter can see that the core is waiting. Every pin group has its own output enable: one for address and control, one for data. The pads themselves are not part of this block.

Top module: `ext_port_arb`

## Requirements
- R1: `bus_sel_n` is {program, data, x/y}, all active low. It reads 011 for program (core_space 0), 101 for X data (1), 100 for Y data (2), 010 for exception fetch (3), and 111 when no access is running. The codes 000, 001 and 110 never appear while outputs are enabled.
- R2: An access taken from idle gives one setup clock with `bus_bs_n` low and both strobes high. This is followed by at least one strobe clock with `bus_rd_n` (read) or `bus_wr_n` (write) low and `bus_bs_n` low. `core_done` pulses for one clock right after the last strobe clock. A new access is not taken in the done clock.
- R3: Every clock edge in the strobe phase that finds `bus_wait` high adds one more strobe clock.
- R4: `bus_addr` changes only at the edge that starts a new access. Between accesses it keeps the last address.
- R5: `bus_data_oe` is high only during write strobe clocks, and then `bus_dout` equals the write data. On a read, the `bus_din` value present at the last strobe edge appears on `core_rdata` with `core_done`.
- R6: `ext_req_n` passes through two flip-flops. Once it is seen, the bus is released only when `core_boundary` is high and no access is in flight. The release takes two steps: `bus_ctl_oe` falls at one edge, and `bus_grant_n` goes low at the next edge.
- R7: The clock after the synchronized request is seen deasserted, `bus_grant_n` returns high while the outputs stay floated. `bus_ctl_oe` returns one clock later.
- R8: While the bus is not owned and `core_req` is high, `core_stall` is high and `bus_need_n` is low. Once ownership returns, the pending access starts.
- R9: While reset is active, `bus_ctl_oe` and `bus_data_oe` are low, and `bus_grant_n`, `bus_bs_n` and `bus_need_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core needs an external access; held until `core_done` |
| core_space | input | 2 | 0 program, 1 X data, 2 Y data, 3 exception fetch |
| core_wr | input | 1 | 1 write, 0 read |
| core_addr | input | AW | Access address |
| core_wdata | input | DW | Write data |
| core_boundary | input | 1 | Core is at an instruction boundary |
| core_done | output | 1 | One-clock access completion |
| core_rdata | output | DW | Read data, valid with `core_done` |
| core_stall | output | 1 | Core waits for bus ownership |
| bus_addr | output | AW | Address pins |
| bus_ctl_oe | output | 1 | Enable for address, selects, strobes and bus strobe |
| bus_sel_n | output | 3 | Space selects {program, data, x/y}, active low |
| bus_bs_n | output | 1 | Bus strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DW | Write data pins |
| bus_data_oe | output | 1 | Enable for data pins |
| bus_din | input | DW | Read data pins |
| bus_wait | input | 1 | External wait request |
| ext_req_n | input | 1 | External bus request, active low, asynchronous |
| bus_grant_n | output | 1 | Bus grant, active low |
| bus_need_n | output | 1 | Bus needed, active low |

## Verification
The hardest state to reach from the ports is an external request that arrives in the middle of an access that is being stretched by wait states. In that case the release must be held off until the strobe finishes, and it may still go ahead in the done clock. The stimulus drives the request low right after the setup clock, holds the access with several wait clocks, and checks at every strobe clock that the outputs stay enabled. The same path is then followed into a grant while a second access is pending. This exercises stall, bus-needed, and the order in which grant drops and the outputs are re-enabled, before the queued access goes out. Random accesses with random wait counts and idle gaps cover the select codes and address holding.

// File: rtl/ext_port_pkg.sv
package ext_port_pkg;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_XDAT = 2'd1,
    SP_YDAT = 2'd2,
    SP_EXC  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    OW_OWNED   = 2'd0,
    OW_FLOAT   = 2'd1,
    OW_GRANTED = 2'd2,
    OW_RETURN  = 2'd3
  } own_e;

  localparam logic [2:0] SEL_IDLE = 3'b111;

  // active-low {program, data, x/y}
  function automatic logic [2:0] sel_code(space_e s);
    logic [2:0] c;
    case (s)
      SP_PROG: c = 3'b011;
      SP_XDAT: c = 3'b101;
      SP_YDAT: c = 3'b100;
      default: c = 3'b010;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ep_sync_chain.sv
module ep_sync_chain #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_first
        assign d_in = d;
      end else begin : g_next
        assign d_in = chain_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= d_in;
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ep_own_fsm.sv
module ep_own_fsm
  import ext_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic boundary,
  input  logic seq_busy,
  output own_e own_st,
  output logic rel_go
);
  own_e st_q, st_d;

  assign rel_go = (st_q == OW_OWNED) && req_s && boundary && !seq_busy;

  always_comb begin
    st_d = st_q;
    case (st_q)
      OW_OWNED:   if (rel_go) st_d = OW_FLOAT;
      OW_FLOAT:   st_d = OW_GRANTED;
      OW_GRANTED: if (!req_s) st_d = OW_RETURN;
      default:    st_d = OW_OWNED;
    endcase
  end

  // reset lands in RETURN: outputs floated, grant off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= OW_RETURN;
    else        st_q <= st_d;
  end

  assign own_st = st_q;
endmodule

// File: rtl/ep_access_seq.sv
module ep_access_seq
  import ext_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  space_e        req_space,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_din,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [2:0]    sel_n,
  output logic          bs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          wr_drive,
  output logic [DW-1:0] wdata
);
  seq_e          st_q, st_d;
  space_e        sp_q, sp_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          done_q, done_d;
  logic          latch_en;
  logic          cap_en;

  always_comb begin
    st_d     = st_q;
    done_d   = 1'b0;
    latch_en = 1'b0;
    cap_en   = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d     = SQ_SETUP;
          latch_en = 1'b1;
        end
      end
      SQ_SETUP: st_d = SQ_STROBE;
      SQ_STROBE: begin
        if (!bus_wait) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
          cap_en = !wr_q;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // request field latches, enabled only on start
  always_comb begin
    sp_d   = sp_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    if (latch_en) begin
      sp_d   = req_space;
      wr_d   = req_wr;
      addr_d = req_addr;
      wd_d   = req_wdata;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (cap_en) rd_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      sp_q   <= SP_PROG;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sp_q   <= sp_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      done_q <= done_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign done     = done_q;
  assign rdata    = rd_q;
  assign addr     = addr_q;
  assign wdata    = wd_q;
  assign sel_n    = busy ? sel_code(sp_q) : SEL_IDLE;
  assign bs_n     = !busy;
  assign rd_n     = !((st_q == SQ_STROBE) && !wr_q);
  assign wr_n     = !((st_q == SQ_STROBE) && wr_q);
  assign wr_drive = (st_q == SQ_STROBE) && wr_q;
endmodule

// File: rtl/ext_port_arb.sv
module ext_port_arb
  import ext_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 24,
  parameter int REQ_SYNC = 2,
  parameter int RST_SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic [1:0]    core_space,
  input  logic          core_wr,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_boundary,
  output logic          core_done,
  output logic [DW-1:0] core_rdata,
  output logic          core_stall,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ctl_oe,
  output logic [2:0]    bus_sel_n,
  output logic          bus_bs_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_wait,
  input  logic          ext_req_n,
  output logic          bus_grant_n,
  output logic          bus_need_n
);
  logic   rst_int_n;
  logic   req_s;
  logic   seq_busy;
  logic   seq_done;
  logic   rel_go;
  logic   start;
  logic   wr_drive;
  logic   alive_q;
  own_e   own_st;

  // asynchronous assertion, synchronous release
  ep_sync_chain #(.STAGES(RST_SYNC), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  ep_sync_chain #(.STAGES(REQ_SYNC), .RST_VAL(1'b0)) u_req_sync (
    .clk(clk), .rst_n(rst_int_n), .d(!ext_req_n), .q(req_s)
  );

  ep_own_fsm u_own (
    .clk(clk), .rst_n(rst_int_n), .req_s(req_s), .boundary(core_boundary),
    .seq_busy(seq_busy), .own_st(own_st), .rel_go(rel_go)
  );

  assign start = core_req && !seq_busy && !seq_done &&
                 (own_st == OW_OWNED) && !rel_go;

  ep_access_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .req_space(space_e'(core_space)), .req_wr(core_wr),
    .req_addr(core_addr), .req_wdata(core_wdata),
    .bus_wait(bus_wait), .bus_din(bus_din),
    .busy(seq_busy), .done(seq_done), .rdata(core_rdata),
    .addr(bus_addr), .sel_n(bus_sel_n), .bs_n(bus_bs_n),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .wr_drive(wr_drive),
    .wdata(bus_dout)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) alive_q <= 1'b0;
    else            alive_q <= 1'b1;
  end

  assign bus_ctl_oe  = (own_st == OW_OWNED);
  assign bus_data_oe = bus_ctl_oe && wr_drive;
  assign bus_grant_n = (own_st != OW_GRANTED);
  assign core_done   = seq_done;
  assign core_stall  = alive_q && core_req && !seq_busy && !seq_done && !start;
  assign bus_need_n  = !(alive_q && (seq_busy || (core_req && !seq_done)));
endmodule

// File: rtl/ep_port_checker.sv
module ep_port_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_stall,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ctl_oe,
  input logic [2:0]    bus_sel_n,
  input logic          bus_bs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_data_oe,
  input logic          bus_wait,
  input logic          bus_grant_n,
  input logic          bus_need_n
);
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ctl_oe |-> (bus_sel_n != 3'b000 && bus_sel_n != 3'b001 && bus_sel_n != 3'b110));

  p_setup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_bs_n) |-> (bus_rd_n && bus_wr_n));

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_bs_n) |=> (!bus_rd_n || !bus_wr_n));

  p_wait_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_rd_n || !bus_wr_n) && bus_wait) |=> (!bus_rd_n || !bus_wr_n));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bs_n |=> (!bus_bs_n || $stable(bus_addr)));

  p_data_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (!bus_wr_n && bus_ctl_oe));

  p_grant_floated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> (!bus_ctl_oe && !bus_data_oe));

  p_grant_drop_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant_n) |-> !bus_ctl_oe);

  p_stall_need_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> !bus_need_n);
endmodule

bind ext_port_arb ep_port_checker #(.AW(AW)) u_port_chk (
  .clk(clk), .rst_n(rst_n), .core_stall(core_stall), .bus_addr(bus_addr),
  .bus_ctl_oe(bus_ctl_oe), .bus_sel_n(bus_sel_n), .bus_bs_n(bus_bs_n),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_data_oe(bus_data_oe),
  .bus_wait(bus_wait), .bus_grant_n(bus_grant_n), .bus_need_n(bus_need_n)
);

// File: tb/test_ext_port_arb.sv
module test_ext_port_arb;
  localparam int AW = 16;
  localparam int DW = 24;

  logic          clk;
  logic          rst_n;
  logic          core_req;
  logic [1:0]    core_space;
  logic          core_wr;
  logic [AW-1:0] core_addr;
  logic [DW-1:0] core_wdata;
  logic          core_boundary;
  logic          core_done;
  logic [DW-1:0] core_rdata;
  logic          core_stall;
  logic [AW-1:0] bus_addr;
  logic          bus_ctl_oe;
  logic [2:0]    bus_sel_n;
  logic          bus_bs_n;
  logic          bus_rd_n;
  logic          bus_wr_n;
  logic [DW-1:0] bus_dout;
  logic          bus_data_oe;
  logic [DW-1:0] bus_din;
  logic          bus_wait;
  logic          ext_req_n;
  logic          bus_grant_n;
  logic          bus_need_n;

  int checks;
  int errors;
  int cycles;
  bit finished;

  ext_port_arb #(.AW(AW), .DW(DW)) i_ext_port_arb (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [2:0] exp_sel(logic [1:0] sp);
    case (sp)
      2'd0:    return 3'b011;
      2'd1:    return 3'b101;
      2'd2:    return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  // Called at a negedge where the request is driven and the next edge starts SETUP.
  task automatic run_access(logic [1:0] sp, logic wr, logic [AW-1:0] a,
                            logic [DW-1:0] wd, logic [DW-1:0] din, int nwait,
                            bit ext_mid);
    core_req = 1'b1; core_space = sp; core_wr = wr; core_addr = a; core_wdata = wd;
    nclk();
    chk("R2 setup bs", bus_bs_n, 0);
    chk("R1 select", bus_sel_n, exp_sel(sp));
    chk("R2 setup strobes", {bus_rd_n, bus_wr_n}, 2'b11);
    chk("R4 addr", bus_addr, a);
    if (ext_mid) ext_req_n = 1'b0;
    nclk();
    for (int k = 0; k <= nwait; k++) begin
      chk("R3 strobe", {bus_rd_n, bus_wr_n}, wr ? 2'b10 : 2'b01);
      chk("R2 bs in strobe", bus_bs_n, 0);
      chk("R6 held during access", bus_ctl_oe, 1);
      chk("R5 data oe", bus_data_oe, wr);
      if (wr) chk("R5 dout", bus_dout, wd);
      chk("R2 no early done", core_done, 0);
      bus_din = din;
      bus_wait = (k < nwait);
      nclk();
    end
    bus_wait = 1'b0;
    chk("R2 done", core_done, 1);
    chk("R2 bs released", bus_bs_n, 1);
    chk("R1 idle select", bus_sel_n, 3'b111);
    chk("R4 addr hold", bus_addr, a);
    if (!wr) chk("R5 rdata", core_rdata, din);
    core_req = 1'b0;
    nclk();
    chk("R2 done pulse", core_done, 0);
    chk("R4 addr hold idle", bus_addr, a);
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; finished = 1'b0;
    void'($urandom(32'd7321));
    rst_n = 1'b0; core_req = 1'b0; core_space = 2'd0; core_wr = 1'b0;
    core_addr = '0; core_wdata = '0; core_boundary = 1'b1;
    bus_din = '0; bus_wait = 1'b0; ext_req_n = 1'b1;
    repeat (3) nclk();
    chk("R9 ctl_oe", bus_ctl_oe, 0);
    chk("R9 data_oe", bus_data_oe, 0);
    chk("R9 grant", bus_grant_n, 1);
    chk("R9 bs", bus_bs_n, 1);
    chk("R9 need", bus_need_n, 1);
    rst_n = 1'b1;
    repeat (5) nclk();
    chk("R9 owned after reset", bus_ctl_oe, 1);
    chk("R1 idle", bus_sel_n, 3'b111);

    // directed: every space, read and write
    for (int s = 0; s < 4; s++) begin
      run_access(2'(s), 1'b0, AW'(16'h1000 + s), '0, DW'(24'hA5A500 + s), 0, 1'b0);
      run_access(2'(s), 1'b1, AW'(16'h2000 + s), DW'(24'h5A5A00 + s), '0, 1, 1'b0);
    end

    // random accesses with idle gaps
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      int gap;
      a = AW'($urandom);
      run_access(2'($urandom_range(0, 3)), 1'($urandom), a, DW'($urandom),
                 DW'($urandom), $urandom_range(0, 3), 1'b0);
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        nclk();
        chk("R4 idle addr", bus_addr, a);
        chk("R1 idle sel", bus_sel_n, 3'b111);
      end
    end

    // release held off by boundary
    core_boundary = 1'b0;
    ext_req_n = 1'b0;
    repeat (6) nclk();
    chk("R6 no release off boundary", bus_ctl_oe, 1);
    chk("R6 no grant off boundary", bus_grant_n, 1);
    core_boundary = 1'b1;
    nclk();
    chk("R6 float", bus_ctl_oe, 0);
    chk("R6 grant not yet", bus_grant_n, 1);
    nclk();
    chk("R6 grant", bus_grant_n, 0);
    ext_req_n = 1'b1;
    repeat (3) nclk();
    chk("R7 grant drop", bus_grant_n, 1);
    chk("R7 still floated", bus_ctl_oe, 0);
    nclk();
    chk("R7 reclaimed", bus_ctl_oe, 1);

    // request arrives during a stretched access
    run_access(2'd1, 1'b0, 16'h3333, '0, 24'h00BEEF, 3, 1'b1);
    chk("R6 float after access", bus_ctl_oe, 0);
    nclk();
    chk("R6 grant after access", bus_grant_n, 0);

    // core needs bus while granted
    core_req = 1'b1; core_space = 2'd3; core_wr = 1'b1;
    core_addr = 16'h4444; core_wdata = 24'h123456;
    repeat (3) begin
      nclk();
      chk("R8 stall", core_stall, 1);
      chk("R8 need", bus_need_n, 0);
      chk("R8 no strobe", bus_bs_n, 1);
    end
    ext_req_n = 1'b1;
    repeat (3) nclk();
    chk("R7 grant drop first", bus_grant_n, 1);
    chk("R7 oe still off", bus_ctl_oe, 0);
    chk("R8 still stalled", core_stall, 1);
    nclk();
    chk("R7 oe back", bus_ctl_oe, 1);
    chk("R8 stall cleared", core_stall, 0);
    run_access(2'd3, 1'b1, 16'h4444, 24'h123456, '0, 0, 1'b0);
    chk("R8 need cleared", bus_need_n, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule